// File: doc/BRIEF.md
# Synchronous Master Serial Receiver

This block is the receive half of a clocked serial port that owns the bus clock. It generates the serial clock from a programmable divider and samples the incoming data line once per bit, at the moment the clock goes low. Bits are assembled least significant first into an 8-bit word, or into a 9-bit word when the ninth-bit option is on. Each finished word goes into a small receive queue. The ninth bit travels in the queue beside its byte.

Two enables start reception. A one-shot request arms a single-word enable, which drops by itself when the word completes. A level continuous enable keeps words coming back to back until it is released. When both are active, continuous operation governs. A word that completes while the queue is full sets a sticky overrun flag and is thrown away. While that flag is up, no further words are queued. The flag goes away only when the continuous enable goes from 1 to 0.

The controller has three states. IDLE holds the clock low and waits for an enable (IDLE→LOW). LOW is the low half of a bit cell and moves to HIGH when its half-period timer expires (LOW→HIGH). HIGH is the high half. When its timer expires, the data line is sampled. If that bit is not the last, the controller returns to LOW (HIGH→LOW). If it is the last bit, the controller goes to LOW when continuous mode is on or to IDLE otherwise. From LOW or HIGH it aborts to IDLE whenever both enables are clear (LOW→IDLE, HIGH→IDLE).

Top module: `sync_master_rx`

## Requirements
- R1: After reset, `sclk_o`, `rx_ready_o`, `ovr_o` and `single_en_o` are all 0.
- R2: A one-cycle pulse on `single_req_i` sets `single_en_o`. The block then clocks in exactly one word. `single_en_o` returns to 0 on the clock edge where `sclk_o` falls for the last bit, and `sclk_o` stays low afterwards.
- R3: While `cont_en_i` is 1, words follow each other with no idle gap. If both enables are set, continuous operation wins: the clock keeps running after the first word, and `single_en_o` is still cleared when that first word completes.
- R4: Each bit cell lasts 4×(`div_i`+1) system clocks: `sclk_o` is low for 2×(`div_i`+1) clocks and then high for 2×(`div_i`+1) clocks. In continuous mode the next rising edge follows the last falling edge of the previous word after exactly 2×(`div_i`+1) clocks.
- R5: `sdat_i` is sampled in the last system cycle of each high half, that is, at the edge where `sclk_o` falls. The first bit received is bit 0. A word has 8 bits when `nine_en_i`=0 and 9 bits when `nine_en_i`=1.
- R6: A completed word enters the queue on the same clock edge where `sclk_o` falls for its last bit. `rx_ready_o` is 1 whenever the queue holds at least one word.
- R7: The queue holds two words and delivers them in arrival order. `rdata_o` shows the oldest word. A `pop_i` pulse removes that word, and a `pop_i` while the queue is empty has no effect.
- R8: If the queue is full when a word completes, `ovr_o` becomes 1 on that edge and the word is dropped. The queued words are unchanged.
- R9: While `ovr_o` is 1, no completed word is queued. `ovr_o` stays 1 until `cont_en_i` changes from 1 to 0, and it is 0 from the following cycle.
- R10: `rx9_o` is the ninth bit of the word currently shown on `rdata_o`, so it advances together with the data on every pop. It is 0 for words received in 8-bit mode and while the queue is empty.
- R11: `rx_ready_o` returns to 0 once pops have emptied the queue.
- R12: If `cont_en_i` is cleared while a word is being shifted and `single_en_o` is 0, the block returns to IDLE in the next cycle with `sclk_o` low. The partial word is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_i | input | DIV_W | Baud divider; bit cell is 4×(div_i+1) clocks |
| nine_en_i | input | 1 | 1 selects 9-bit words |
| single_req_i | input | 1 | One-cycle pulse that arms single-word reception |
| cont_en_i | input | 1 | Continuous reception enable (level) |
| sclk_o | output | 1 | Generated serial clock, idles low |
| sdat_i | input | 1 | Serial data line |
| pop_i | input | 1 | Read strobe that removes the oldest queued word |
| rdata_o | output | 8 | Data byte of the oldest queued word |
| rx9_o | output | 1 | Ninth bit of the oldest queued word |
| rx_ready_o | output | 1 | Queue holds at least one word |
| ovr_o | output | 1 | Sticky overrun flag |
| single_en_o | output | 1 | Single-word enable state |

## Verification
The queue push, the overrun flag and the clearing of `single_en_o` all take effect on the edge where `sclk_o` falls for the last bit. The bench therefore waits for that falling edge and samples on the next falling edge of the system clock, half a cycle later. A pop takes effect at the first rising edge after it is driven, and the overrun flag clears one edge after `cont_en_i` drops, so both are checked on the following falling edge of `clk`. Bit-cell length and the gap between words are measured from the recorded times of `sclk_o` edges and compared with 4×(div+1) and 2×(div+1) clock periods. Serial data is changed just after each rising edge of `sclk_o`, which keeps it stable across the sampling edge.

// File: rtl/smrx_pkg.sv
package smrx_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned WORD_W = BYTE_W + 1;
    localparam int unsigned BITCNT_W = $clog2(WORD_W + 1);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } rx_state_t;

    typedef struct packed {
        logic              b9;
        logic [BYTE_W-1:0] data;
    } rx_entry_t;

endpackage

// File: rtl/smrx_halftimer.sv
module smrx_halftimer #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             half_end
);
    localparam int unsigned CNT_W = DIV_W + 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;

    // half period = 2*(div+1) cycles, so the last count is 2*div+1
    always_comb begin
        limit    = {div, 1'b1};
        half_end = run && (cnt == limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || half_end) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/smrx_ctrl.sv
module smrx_ctrl
    import smrx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      single_req,
    input  logic      cont_en,
    input  logic      nine_en,
    input  logic      half_end,
    input  logic      sdat,
    output logic      sclk,
    output logic      running,
    output logic      single_en,
    output logic      word_done,
    output rx_entry_t word
);
    rx_state_t state, state_nx;

    logic [BITCNT_W-1:0] bitcnt;
    logic [WORD_W-1:0]   shreg;
    logic [WORD_W-1:0]   assembled;
    logic                any_en;
    logic                last_bit;
    logic                sample;

    always_comb begin
        any_en   = cont_en || single_en;
        last_bit = (bitcnt == (nine_en ? BITCNT_W'(WORD_W - 1) : BITCNT_W'(BYTE_W - 1)));
        sample   = (state == ST_HIGH) && half_end && any_en;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (any_en) state_nx = ST_LOW;
            end
            ST_LOW: begin
                if (!any_en)       state_nx = ST_IDLE;
                else if (half_end) state_nx = ST_HIGH;
            end
            ST_HIGH: begin
                if (!any_en) begin
                    state_nx = ST_IDLE;
                end else if (half_end) begin
                    if (last_bit && !cont_en) state_nx = ST_IDLE;
                    else                      state_nx = ST_LOW;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // outputs decoded from the state register
    always_comb begin
        sclk      = 1'b0;
        running   = 1'b0;
        word_done = 1'b0;
        unique case (state)
            ST_IDLE: begin
                sclk    = 1'b0;
                running = 1'b0;
            end
            ST_LOW: begin
                sclk    = 1'b0;
                running = 1'b1;
            end
            ST_HIGH: begin
                sclk      = 1'b1;
                running   = 1'b1;
                word_done = sample && last_bit;
            end
            default: begin
                sclk    = 1'b0;
                running = 1'b0;
            end
        endcase
    end

    // word seen at the final sampling edge, including the bit sampled now
    always_comb begin
        assembled         = (bitcnt == '0) ? '0 : shreg;
        assembled[bitcnt] = sdat;
        word.data         = assembled[BYTE_W-1:0];
        word.b9           = nine_en && assembled[WORD_W-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt <= '0;
            shreg  <= '0;
        end else if (state == ST_IDLE || !any_en) begin
            bitcnt <= '0;
        end else if (sample) begin
            shreg  <= assembled;
            bitcnt <= last_bit ? '0 : bitcnt + 1'b1;
        end
    end

    // one-shot enable: a request sets it, completion of a word clears it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            single_en <= 1'b0;
        end else if (single_req) begin
            single_en <= 1'b1;
        end else if (word_done) begin
            single_en <= 1'b0;
        end
    end

endmodule

// File: rtl/smrx_fifo.sv
module smrx_fifo #(
    parameter int unsigned DEPTH = 2,
    parameter int unsigned W     = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic [CNT_W-1:0] cnt;
    logic             do_push, do_pop;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        empty   = (cnt == '0);
        full    = (cnt == CNT_W'(DEPTH));
        do_push = push && !full;
        do_pop  = pop && !empty;
        dout    = mem[rd_ptr];
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem[g] <= '0;
            end else if (do_push && wr_ptr == PTR_W'(g)) begin
                mem[g] <= din;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= ptr_next(wr_ptr);
            if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
            cnt <= cnt + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

endmodule

// File: rtl/sync_master_rx.sv
module sync_master_rx
    import smrx_pkg::*;
#(
    parameter int unsigned DIV_W      = 8,
    parameter int unsigned FIFO_DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    input  logic             nine_en_i,
    input  logic             single_req_i,
    input  logic             cont_en_i,
    output logic             sclk_o,
    input  logic             sdat_i,
    input  logic             pop_i,
    output logic [7:0]       rdata_o,
    output logic             rx9_o,
    output logic             rx_ready_o,
    output logic             ovr_o,
    output logic             single_en_o
);
    logic         half_end;
    logic         running;
    logic         word_done;
    rx_entry_t    word;
    logic [WORD_W-1:0] head;
    logic         q_empty, q_full;
    logic         push;
    logic         cont_q;
    logic         ovr;

    smrx_halftimer #(.DIV_W(DIV_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (running),
        .div      (div_i),
        .half_end (half_end)
    );

    smrx_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .single_req (single_req_i),
        .cont_en    (cont_en_i),
        .nine_en    (nine_en_i),
        .half_end   (half_end),
        .sdat       (sdat_i),
        .sclk       (sclk_o),
        .running    (running),
        .single_en  (single_en_o),
        .word_done  (word_done),
        .word       (word)
    );

    smrx_fifo #(.DEPTH(FIFO_DEPTH), .W(WORD_W)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .din   (word),
        .pop   (pop_i),
        .dout  (head),
        .empty (q_empty),
        .full  (q_full)
    );

    assign push = word_done && !ovr && !q_full;

    // sticky overrun: set by a completed word meeting a full queue,
    // cleared only when the continuous enable goes from 1 to 0
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cont_q <= 1'b0;
            ovr    <= 1'b0;
        end else begin
            cont_q <= cont_en_i;
            if (word_done && !ovr && q_full) begin
                ovr <= 1'b1;
            end else if (cont_q && !cont_en_i) begin
                ovr <= 1'b0;
            end
        end
    end

    always_comb begin
        rx_ready_o = !q_empty;
        ovr_o      = ovr;
        rdata_o    = q_empty ? 8'h00 : head[BYTE_W-1:0];
        rx9_o      = !q_empty && head[WORD_W-1];
    end

endmodule

// File: rtl/smrx_checker.sv
module smrx_checker (
    input logic clk,
    input logic rst_n,
    input logic cont_en_i,
    input logic single_en_o,
    input logic sclk_o,
    input logic rx_ready_o,
    input logic ovr_o
);

    AST_READY_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_ready_o) |-> $fell(sclk_o)); // R6

    AST_OVR_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_o) |-> $fell(sclk_o)); // R8

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_o && cont_en_i) |=> ovr_o); // R9

    AST_OVR_BLOCKS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_o |=> !$rose(rx_ready_o)); // R9

    AST_IDLE_CLOCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!cont_en_i && !single_en_o) |=> !sclk_o); // R12

    AST_SINGLE_CLEARS_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(single_en_o) |-> $fell(sclk_o)); // R2

    AST_HIGH_HALF_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_o) |=> sclk_o); // R4

endmodule

bind sync_master_rx smrx_checker u_smrx_chk (.*);

// File: tb/sync_master_rx_bench.sv
`timescale 1ns/1ps
module sync_master_rx_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 6;
    // {nine_en, div[7:0], word[8:0]}
    localparam logic [17:0] VEC [NVEC] = '{
        {1'b0, 8'd0, 9'h0A5},
        {1'b0, 8'd1, 9'h03C},
        {1'b1, 8'd0, 9'h1C3},
        {1'b1, 8'd2, 9'h055},
        {1'b0, 8'd3, 9'h0FF},
        {1'b1, 8'd1, 9'h100}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] div_i = 8'd0;
    logic       nine_en_i = 1'b0;
    logic       single_req_i = 1'b0;
    logic       cont_en_i = 1'b0;
    logic       sclk_o;
    logic       sdat_i = 1'b0;
    logic       pop_i = 1'b0;
    logic [7:0] rdata_o;
    logic       rx9_o;
    logic       rx_ready_o;
    logic       ovr_o;
    logic       single_en_o;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;
    bit  chk_gap = 1'b0;
    time t_fall = 0;

    sync_master_rx u_sync_master_rx (
        .clk          (clk),
        .rst_n        (rst_n),
        .div_i        (div_i),
        .nine_en_i    (nine_en_i),
        .single_req_i (single_req_i),
        .cont_en_i    (cont_en_i),
        .sclk_o       (sclk_o),
        .sdat_i       (sdat_i),
        .pop_i        (pop_i),
        .rdata_o      (rdata_o),
        .rx9_o        (rx9_o),
        .rx_ready_o   (rx_ready_o),
        .ovr_o        (ovr_o),
        .single_en_o  (single_en_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // acts as the remote sender: new bit just after each rising sclk
    task automatic send_word(input logic [8:0] w, input int nbits);
        time t_first;
        for (int i = 0; i < nbits; i++) begin
            @(posedge sclk_o);
            if (i == 0) begin
                t_first = $time;
                if (chk_gap)
                    chk("R4 gap between words", int'((t_first - t_fall) / CLK_PERIOD),
                        2 * (int'(div_i) + 1));
            end
            if (i == 1)
                chk("R4 bit cell length", int'(($time - t_first) / CLK_PERIOD),
                    4 * (int'(div_i) + 1));
            #1 sdat_i = w[i];
        end
        @(negedge sclk_o);
        t_fall = $time;
        @(negedge clk);
    endtask

    task automatic pop_once();
        @(negedge clk);
        pop_i = 1'b1;
        @(negedge clk);
        pop_i = 1'b0;
    endtask

    task automatic pulse_single();
        @(negedge clk);
        single_req_i = 1'b1;
        @(negedge clk);
        single_req_i = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 sclk low in reset", sclk_o, 0);
        chk("R1 ready low in reset", rx_ready_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 sclk after reset", sclk_o, 0);
        chk("R1 ready after reset", rx_ready_o, 0);
        chk("R1 overrun after reset", ovr_o, 0);
        chk("R1 single enable after reset", single_en_o, 0);

        // table-driven single-word receptions (R2 R4 R5 R6 R10 R11)
        for (int v = 0; v < NVEC; v++) begin
            logic       nine;
            logic [8:0] w;
            int         hi_cnt;
            nine = VEC[v][17];
            w    = VEC[v][8:0];
            @(negedge clk);
            nine_en_i = nine;
            div_i     = VEC[v][16:9];
            chk_gap   = 1'b0;
            pulse_single();
            chk("R2 single enable set", single_en_o, 1);
            send_word(w, nine ? 9 : 8);
            chk("R6 ready at last falling edge", rx_ready_o, 1);
            chk("R5 data LSB first", rdata_o, w[7:0]);
            chk("R10 ninth bit", rx9_o, nine ? w[8] : 1'b0);
            chk("R2 single enable self-clears", single_en_o, 0);
            hi_cnt = 0;
            for (int k = 0; k < 8 * (int'(div_i) + 1); k++) begin
                @(negedge clk);
                if (sclk_o) hi_cnt++;
            end
            chk("R2 clock idles low after one word", hi_cnt, 0);
            pop_once();
            chk("R11 ready clears when emptied", rx_ready_o, 0);
        end

        // continuous with single also set: continuous wins (R3), overrun (R8, R9)
        @(negedge clk);
        nine_en_i = 1'b0;
        div_i     = 8'd0;
        cont_en_i = 1'b1;
        single_req_i = 1'b1;
        @(negedge clk);
        single_req_i = 1'b0;
        chk_gap = 1'b0;
        send_word(9'h011, 8);
        chk("R3 single flag cleared in continuous", single_en_o, 0);
        chk("R6 first continuous word queued", rx_ready_o, 1);
        chk_gap = 1'b1;
        send_word(9'h022, 8);
        chk("R3 clock kept running for second word", rx_ready_o, 1);
        send_word(9'h033, 8);
        chk("R8 overrun on full queue", ovr_o, 1);
        chk("R8 oldest word unchanged", rdata_o, 8'h11);
        pop_once();
        chk("R7 second word in order", rdata_o, 8'h22);
        chk("R9 overrun still set", ovr_o, 1);
        pop_once();
        chk("R11 queue empty after two pops", rx_ready_o, 0);
        chk_gap = 1'b0;
        send_word(9'h044, 8);
        chk("R9 no load while overrun set", rx_ready_o, 0);
        chk("R9 overrun sticky", ovr_o, 1);
        @(negedge clk);
        cont_en_i = 1'b0;
        @(negedge clk);
        chk("R9 overrun cleared by cont enable fall", ovr_o, 0);
        chk("R12 abort returns clock low", sclk_o, 0);
        repeat (12) @(negedge clk);
        chk("R12 partial word discarded", rx_ready_o, 0);

        // ninth bit travels with its byte (R10, R7)
        @(negedge clk);
        nine_en_i = 1'b1;
        div_i     = 8'd1;
        cont_en_i = 1'b1;
        chk_gap   = 1'b0;
        send_word(9'h1AA, 9);
        chk_gap = 1'b1;
        send_word(9'h055, 9);
        @(negedge clk);
        cont_en_i = 1'b0;
        @(negedge clk);
        chk("R10 head ninth bit", rx9_o, 1);
        chk("R7 head data", rdata_o, 8'hAA);
        pop_once();
        chk("R10 ninth bit follows pop", rx9_o, 0);
        chk("R7 next data", rdata_o, 8'h55);
        pop_once();
        chk("R11 empty after reads", rx_ready_o, 0);

        // pop on empty queue has no effect (R7)
        pop_once();
        pop_once();
        @(negedge clk);
        nine_en_i = 1'b0;
        div_i     = 8'd0;
        chk_gap   = 1'b0;
        pulse_single();
        send_word(9'h05A, 8);
        chk("R7 empty pop ignored, ready", rx_ready_o, 1);
        chk("R7 empty pop ignored, data", rdata_o, 8'h5A);
        pop_once();
        chk("R7 single entry removed", rx_ready_o, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule